// File: doc/BRIEF.md
# NOR Flash Command Sequence Interpreter

This block models the command front end of a byte-wide parallel NOR flash. It watches asynchronous write cycles, each given by an address, a data byte and an active-low write strobe. The write is taken on the rising edge of the strobe, sampled in the block clock domain. It recognises the multi-cycle unlock sequences for byte program, sector erase and chip erase. A small register array stands in for the flash cells. An erase is simulated as a fixed number of clock cycles for each sector, during which the bytes of that sector are set to all ones.

A sector-erase sequence opens an acceptance window. During the window, further sector-erase writes add sectors to the queue and restart the window. An erase-suspend write ends the window at once. Any other write abandons the operation. Once the erase runs, only suspend is honoured. While suspended, the host may read and program every sector that is not queued. A resume write continues the erase from the point where it stopped. Reads return either array data or a status byte, one cycle after the read request.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset, `busy` is 0, `rd_data` is 0x00 and the block is in array-read mode.
- R2: Every command begins with 0xAA written to address 0x55, then 0x55 written to address 0xAA. A program command follows with 0xA0 at 0x55. An erase follows with 0x80 at 0x55, then 0xAA at 0x55 and 0x55 at 0xAA, and ends with either 0x10 at 0x55 (chip erase) or 0x30 at any address in the target sector (sector erase). A write that does not fit the expected step returns the parser to its idle state and has no other effect.
- R3: A sector-erase sequence opens a window of WIN_CYC cycles, during which `busy` is 1. Each write of 0x30 during the window queues the sector of its address and restarts the full window. The erase begins when the window runs out.
- R4: During the window, a write of any byte other than 0x30 or 0xB0 empties the queue and returns the block to array-read mode, with the array left unchanged.
- R5: A write of 0xB0 during the window ends the window at once and enters the suspended state, with `busy` 0.
- R6: While a sector erase runs, a write of 0xB0 suspends it. Every other write is ignored.
- R7: Chip erase queues every sector with no window. While a chip erase runs, every write is ignored, 0xB0 included.
- R8: In a program command, the write after 0xA0 stores its data byte at its address. `busy` is then 1 for PROG_CYC cycles, during which every write is ignored.
- R9: While suspended, reads of sectors that are not queued return array data, and reads of queued sectors return the status byte. Program commands reach only sectors that are not queued. A write of 0x30, given while no unlock sequence is in progress, resumes the erase.
- R10: The status byte has bit 7 set when the block is suspended and bit 3 set once the acceptance window has expired (erase running, or suspended). All other bits are 0. It is returned for every read while `busy` is 1.
- R11: Each queued sector takes ERASE_CYC cycles of erase, sectors in ascending order. Erased bytes read 0xFF. When the queue empties, the block returns to array-read mode with `busy` 0.
- R12: A read request on `rd_en` is answered on `rd_data` in the next cycle. `rd_data` holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| we_n | input | 1 | Write strobe, active low; the write is taken on its rising edge |
| addr | input | ADDR_W | Byte address for writes and reads |
| wdata | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read request for the byte at `addr` |
| rd_data | output | 8 | Array byte or status byte, registered |
| busy | output | 1 | High during program, the erase window and a running erase |

## Verification
The hardest situations to reach are a suspend that lands partway through a sector erase and a sector added shortly before the window expires. Both depend on the exact cycle on which the strobe edge is seen. The stimulus times its writes by counting cycles from the final strobe edge of the sequence. It places a retriggering write after more than half the window, then reads the status once the first window would already have expired. It suspends an erase after a fixed number of erase cycles, then probes queued and non-queued sectors before it resumes. A behavioural reference model, advanced on every clock, follows `busy` and every read, so any difference in timing shows up on the cycle where it occurs.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_U1,
    ST_U2,
    ST_SET,
    ST_SU1,
    ST_SU2,
    ST_PADDR,
    ST_PBUSY,
    ST_WIN,
    ST_ERASE,
    ST_SUSP
  } fc_state_e;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;  // also resume
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_PROG  = 8'hA0;

endpackage

// File: rtl/nor_cmd_strobe.sv
module nor_cmd_strobe (
  input  logic clk,
  input  logic rst,
  input  logic we_n,
  output logic wr_evt
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign wr_evt = we_n & ~we_q;

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int WIN_CYC   = 20,
  parameter int ERASE_CYC = 80,
  parameter int PROG_CYC  = 6,
  parameter int KEY_ADR1  = 'h55,
  parameter int KEY_ADR2  = 'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              arr_sel,
  output logic [7:0]        status,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic [7:0]        mem_wd
);
  localparam int NSECT = 1 << SECT_W;
  localparam int OFF_W = ADDR_W - SECT_W;
  localparam int SECT_BYTES = 1 << OFF_W;
  localparam int TW = $clog2(WIN_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_ADR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_ADR2);

  fc_state_e          st;
  logic               susp, chip;
  logic [NSECT-1:0]   q, q_rest;
  logic [TW-1:0]      tmr;
  logic [EW-1:0]      cnt;
  logic [PW-1:0]      pcnt;
  logic [SECT_W-1:0]  cur, asec;
  logic               a1, a2, step;
  fc_state_e          home;

  assign asec = addr[ADDR_W-1 -: SECT_W];
  assign a1   = (addr == A1);
  assign a2   = (addr == A2);
  assign home = susp ? ST_SUSP : ST_READ;

  always_comb begin
    cur = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (q[i]) cur = SECT_W'(i);
    end
  end

  always_comb begin
    q_rest = q;
    q_rest[cur] = 1'b0;
  end

  assign step = (st == ST_ERASE) && !(wr_evt && wdata == CMD_SUSP && !chip);

  always_comb begin
    mem_we = 1'b0;
    mem_wa = {cur, cnt[OFF_W-1:0]};
    mem_wd = 8'hFF;
    if (st == ST_PADDR) begin
      mem_we = wr_evt && !(susp && q[asec]);
      mem_wa = addr;
      mem_wd = wdata;
    end else if (step && int'(cnt) < SECT_BYTES) begin
      mem_we = 1'b1;
    end
  end

  assign arr_sel = (st inside {ST_READ, ST_U1, ST_U2, ST_SET, ST_SU1, ST_SU2,
                               ST_PADDR, ST_SUSP}) && !(susp && q[asec]);
  assign status  = {susp, 3'b000, (st == ST_ERASE) || susp, 3'b000};
  assign busy    = st inside {ST_PBUSY, ST_WIN, ST_ERASE};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_READ;
      susp <= 1'b0;
      chip <= 1'b0;
      q    <= '0;
      tmr  <= '0;
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      case (st)
        ST_READ, ST_SUSP: if (wr_evt) begin
          if (wdata == CMD_KEY1 && a1) st <= ST_U1;
          else if (st == ST_SUSP && wdata == CMD_SECT) begin
            st   <= ST_ERASE;
            susp <= 1'b0;
          end
        end
        ST_U1: if (wr_evt) st <= (wdata == CMD_KEY2 && a2) ? ST_U2 : home;
        ST_U2: if (wr_evt) begin
          if (wdata == CMD_PROG && a1) st <= ST_PADDR;
          else if (wdata == CMD_SETUP && a1 && !susp) st <= ST_SET;
          else st <= home;
        end
        ST_SET: if (wr_evt) st <= (wdata == CMD_KEY1 && a1) ? ST_SU1 : home;
        ST_SU1: if (wr_evt) st <= (wdata == CMD_KEY2 && a2) ? ST_SU2 : home;
        ST_SU2: if (wr_evt) begin
          if (wdata == CMD_CHIP && a1) begin
            q    <= '1;
            chip <= 1'b1;
            cnt  <= '0;
            st   <= ST_ERASE;
          end else if (wdata == CMD_SECT) begin
            q[asec] <= 1'b1;
            tmr     <= TW'(WIN_CYC);
            cnt     <= '0;
            st      <= ST_WIN;
          end else begin
            st <= home;
          end
        end
        ST_PADDR: if (wr_evt) begin
          st   <= ST_PBUSY;
          pcnt <= PW'(PROG_CYC);
        end
        ST_PBUSY: begin
          if (pcnt <= 1) st <= home;
          else pcnt <= pcnt - 1'b1;
        end
        ST_WIN: begin
          if (wr_evt) begin
            if (wdata == CMD_SECT) begin
              q[asec] <= 1'b1;
              tmr     <= TW'(WIN_CYC);
            end else if (wdata == CMD_SUSP) begin
              st   <= ST_SUSP;
              susp <= 1'b1;
            end else begin
              st <= ST_READ;
              q  <= '0;
            end
          end else if (tmr <= 1) begin
            st <= ST_ERASE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_ERASE: begin
          if (!step) begin
            st   <= ST_SUSP;
            susp <= 1'b1;
          end else if (cnt == EW'(ERASE_CYC - 1)) begin
            cnt    <= '0;
            q[cur] <= 1'b0;
            if (q_rest == '0) begin
              st   <= ST_READ;
              chip <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_READ;
      endcase
    end
  end

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WIN && !wr_evt && tmr > 1) |=> (st == ST_WIN));

  // R4
  win_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WIN && wr_evt && wdata != CMD_SECT && wdata != CMD_SUSP)
      |=> (st == ST_READ && q == '0));

  // R5
  win_susp_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WIN && wr_evt && wdata == CMD_SUSP) |=> (st == ST_SUSP && !busy));

  // R6
  erase_only_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE && !(wr_evt && wdata == CMD_SUSP))
      |=> (st == ST_ERASE || st == ST_READ));

  // R7
  chip_nosusp_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE && chip) |=> !susp);

  // R9
  susp_work_chk: assert property (@(posedge clk) disable iff (rst)
    susp |-> (q != '0));

  // R11
  erase_queue_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE) |-> (q != '0));

endmodule

// File: rtl/nor_cmd_store.sv
module nor_cmd_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              arr_sel,
  input  logic [7:0]        status,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= arr_sel ? mem[rd_addr] : status;
  end

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int WIN_CYC   = 20,
  parameter int ERASE_CYC = 80,
  parameter int PROG_CYC  = 6,
  parameter int KEY_ADR1  = 'h55,
  parameter int KEY_ADR2  = 'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              busy
);
  logic              wr_evt, arr_sel, mem_we;
  logic [7:0]        status, mem_wd;
  logic [ADDR_W-1:0] mem_wa;

  nor_cmd_strobe strobe_i (
    .clk    (clk),
    .rst    (rst),
    .we_n   (we_n),
    .wr_evt (wr_evt)
  );

  nor_cmd_fsm #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .WIN_CYC   (WIN_CYC),
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .KEY_ADR1  (KEY_ADR1),
    .KEY_ADR2  (KEY_ADR2)
  ) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .wr_evt  (wr_evt),
    .addr    (addr),
    .wdata   (wdata),
    .arr_sel (arr_sel),
    .status  (status),
    .busy    (busy),
    .mem_we  (mem_we),
    .mem_wa  (mem_wa),
    .mem_wd  (mem_wd)
  );

  nor_cmd_store #(.ADDR_W(ADDR_W)) store_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (addr),
    .arr_sel (arr_sel),
    .status  (status),
    .we      (mem_we),
    .wa      (mem_wa),
    .wd      (mem_wd),
    .rd_data (rd_data)
  );

  // R1
  busy_reset_chk: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && rd_data == 8'h00));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
  localparam int AW = 8;
  localparam int DEPTH = 256;
  localparam int SBYTES = 64;
  localparam int NS = 4;
  localparam int WIN = 20;
  localparam int ERC = 80;
  localparam int PRC = 6;
  localparam int LIMIT = 150000;
  localparam int M_IDLE = 0, M_PROG = 1, M_WIN = 2, M_ERASE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic busy;

  always #2 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .SECT_W(2), .WIN_CYC(WIN), .ERASE_CYC(ERC),
                .PROG_CYC(PRC), .KEY_ADR1('h55), .KEY_ADR2('hAA)) dut_i (
    .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy));

  int unsigned vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  logic [7:0] mmem [DEPTH];
  bit mkn [DEPTH];
  bit qd [NS];
  int m_mode, m_step, m_wleft, m_ecnt, m_pleft, m_sec, m_cur;
  bit m_susp, m_chip, m_weq, m_ev, m_known, m_any;
  logic [7:0] m_rd;

  initial for (int i = 0; i < DEPTH; i++) mkn[i] = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = M_IDLE; m_step = 0; m_susp = 0; m_chip = 0; m_weq = 1;
      m_rd = 8'h00; m_known = 1; m_wleft = 0; m_ecnt = 0; m_pleft = 0;
      for (int i = 0; i < NS; i++) qd[i] = 0;
    end else begin
      m_ev = we_n && !m_weq;
      m_weq = we_n;
      m_sec = int'(addr) / SBYTES;
      if (rd_en) begin
        if (m_mode == M_IDLE && !(m_susp && qd[m_sec])) begin
          m_rd = mmem[addr]; m_known = mkn[addr];
        end else begin
          m_rd = {m_susp, 3'b000, (m_mode == M_ERASE) || m_susp, 3'b000};
          m_known = 1;
        end
      end
      case (m_mode)
        M_IDLE: if (m_ev) begin
          if (m_step == 6) begin
            if (!(m_susp && qd[m_sec])) begin mmem[addr] = wdata; mkn[addr] = 1; end
            m_mode = M_PROG; m_pleft = PRC; m_step = 0;
          end else if (m_step == 0 && wdata == 8'hAA && addr == 8'h55) m_step = 1;
          else if (m_step == 0 && m_susp && wdata == 8'h30) begin
            m_susp = 0; m_mode = M_ERASE;
          end
          else if (m_step == 1 && wdata == 8'h55 && addr == 8'hAA) m_step = 2;
          else if (m_step == 2 && wdata == 8'hA0 && addr == 8'h55) m_step = 6;
          else if (m_step == 2 && wdata == 8'h80 && addr == 8'h55 && !m_susp) m_step = 3;
          else if (m_step == 3 && wdata == 8'hAA && addr == 8'h55) m_step = 4;
          else if (m_step == 4 && wdata == 8'h55 && addr == 8'hAA) m_step = 5;
          else if (m_step == 5 && wdata == 8'h10 && addr == 8'h55) begin
            for (int i = 0; i < NS; i++) qd[i] = 1;
            m_chip = 1; m_ecnt = 0; m_mode = M_ERASE; m_step = 0;
          end else if (m_step == 5 && wdata == 8'h30) begin
            qd[m_sec] = 1; m_wleft = WIN; m_ecnt = 0; m_mode = M_WIN; m_step = 0;
          end else m_step = 0;
        end
        M_PROG: begin
          m_pleft--;
          if (m_pleft == 0) m_mode = M_IDLE;
        end
        M_WIN: begin
          if (m_ev) begin
            if (wdata == 8'h30) begin qd[m_sec] = 1; m_wleft = WIN; end
            else if (wdata == 8'hB0) begin m_susp = 1; m_mode = M_IDLE; end
            else begin
              m_mode = M_IDLE;
              for (int i = 0; i < NS; i++) qd[i] = 0;
            end
          end else begin
            m_wleft--;
            if (m_wleft == 0) m_mode = M_ERASE;
          end
        end
        default: begin
          if (m_ev && wdata == 8'hB0 && !m_chip) begin
            m_susp = 1; m_mode = M_IDLE;
          end else begin
            m_cur = -1;
            for (int i = NS - 1; i >= 0; i--) if (qd[i]) m_cur = i;
            if (m_ecnt < SBYTES) begin
              mmem[m_cur * SBYTES + m_ecnt] = 8'hFF;
              mkn[m_cur * SBYTES + m_ecnt] = 1;
            end
            m_ecnt++;
            if (m_ecnt == ERC) begin
              qd[m_cur] = 0; m_ecnt = 0;
              m_any = 0;
              for (int i = 0; i < NS; i++) m_any |= qd[i];
              if (!m_any) begin m_mode = M_IDLE; m_chip = 0; end
            end
          end
        end
      endcase
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (busy !== (m_mode != M_IDLE)) begin
        miscompares++;
        $display("FAIL %s busy actual=%b expected=%b", cur_req, busy, m_mode != M_IDLE);
      end
      if (m_known) begin
        vectors++;
        if (rd_data !== m_rd) begin
          miscompares++;
          $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, m_rd);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d cycles", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk8(tag, rd_data, exp);
  endtask

  task automatic keys();
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55);
  endtask

  task automatic sect_erase(logic [7:0] a);
    keys(); wr(8'h55, 8'h80); keys(); wr(a, 8'h30);
  endtask

  task automatic prog(logic [7:0] a, logic [7:0] d);
    keys(); wr(8'h55, 8'hA0); wr(a, d);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    chk8("R1 busy after reset", {7'd0, busy}, 8'h00);
    chk8("R1 rd_data after reset", rd_data, 8'h00);

    // R7: chip erase, suspend ignored
    cur_req = "R7";
    keys(); wr(8'h55, 8'h80); keys(); wr(8'h55, 8'h10);
    idle(10);
    wr(8'h00, 8'hB0);
    rd_chk(8'h00, 8'h08, "R7 status during chip erase after suspend");
    chk8("R7 busy kept after suspend", {7'd0, busy}, 8'h01);
    wait_idle();
    cur_req = "R11";
    rd_chk(8'h00, 8'hFF, "R11 chip erased byte s0");
    rd_chk(8'hFF, 8'hFF, "R11 chip erased byte s3");

    // R8: program, writes ignored while busy
    cur_req = "R8";
    prog(8'h05, 8'h12);
    rd_chk(8'h05, 8'h00, "R10 status during program");
    wr(8'h05, 8'hB0);
    wait_idle();
    rd_chk(8'h05, 8'h12, "R8 programmed byte");
    prog(8'h45, 8'h34); wait_idle();
    prog(8'h85, 8'h56); wait_idle();
    prog(8'hC5, 8'h78); wait_idle();
    rd_chk(8'hC5, 8'h78, "R8 programmed byte s3");

    // R2: broken unlock sequence
    cur_req = "R2";
    keys(); wr(8'h10, 8'hA0); wr(8'h05, 8'h77);
    idle(PRC + 2);
    rd_chk(8'h05, 8'h12, "R2 bad step has no effect");
    chk8("R2 busy after bad sequence", {7'd0, busy}, 8'h00);

    // R4: abort during window
    cur_req = "R4";
    sect_erase(8'h40);
    wr(8'h00, 8'hF0);
    idle(2);
    chk8("R4 busy after abort", {7'd0, busy}, 8'h00);
    rd_chk(8'h45, 8'h34, "R4 array unchanged after abort");

    // R3: retriggered multi-sector window, R6 ignored writes
    cur_req = "R3";
    sect_erase(8'h40);
    rd_chk(8'h45, 8'h00, "R10 status inside window");
    idle(10);
    wr(8'hC0, 8'h30);
    idle(15);
    rd_chk(8'h45, 8'h00, "R3 window restarted by added sector");
    idle(10);
    cur_req = "R6";
    rd_chk(8'h45, 8'h08, "R10 status during sector erase");
    wr(8'h00, 8'hF0);
    wr(8'h55, 8'hAA);
    rd_chk(8'h45, 8'h08, "R6 writes ignored during erase");
    wait_idle();
    cur_req = "R11";
    rd_chk(8'h45, 8'hFF, "R11 sector 1 erased");
    rd_chk(8'hC5, 8'hFF, "R11 sector 3 erased");
    rd_chk(8'h05, 8'h12, "R11 sector 0 kept");
    rd_chk(8'h85, 8'h56, "R11 sector 2 kept");

    // R5: suspend inside the window
    cur_req = "R5";
    prog(8'h45, 8'h9A); wait_idle();
    sect_erase(8'h40);
    wr(8'h00, 8'hB0);
    idle(1);
    chk8("R5 busy after suspend in window", {7'd0, busy}, 8'h00);
    rd_chk(8'h45, 8'h88, "R5 status of queued sector");
    wr(8'h00, 8'h30);
    wait_idle();
    rd_chk(8'h45, 8'hFF, "R5 erase completes after resume");

    // R9: suspend mid-erase, program around it
    cur_req = "R9";
    sect_erase(8'h80);
    idle(50);
    wr(8'h00, 8'hB0);
    rd_chk(8'h05, 8'h12, "R9 unqueued sector readable");
    rd_chk(8'h85, 8'h88, "R9 queued sector returns status");
    prog(8'h07, 8'hCD); wait_idle();
    rd_chk(8'h07, 8'hCD, "R9 program to unqueued sector");
    prog(8'h87, 8'h11); wait_idle();
    wr(8'h00, 8'h30);
    wait_idle();
    rd_chk(8'h87, 8'hFF, "R9 program to queued sector ignored");
    rd_chk(8'hBF, 8'hFF, "R11 last byte of sector erased");

    // R12: output holds without read
    cur_req = "R12";
    rd_chk(8'h07, 8'hCD, "R12 read latency");
    @(negedge clk); addr = 8'h05;
    @(negedge clk);
    chk8("R12 rd_data held", rd_data, 8'hCD);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule